// File: doc/BRIEF.md
# Paged ROM Table-Lookup Sequencer

This block carries out a table-reference instruction for a small 4-bit core. The instruction word is `0010` followed by a 6-bit page field. When it is accepted, the sequencer borrows one level of the hardware return stack to save the return address. It then points the program counter at a ROM word in the selected page and reads that 10-bit word. The word is split into a 2-bit W value, a 4-bit B value and a 4-bit A value. Finally the sequencer restores the program counter and releases the stack level. A lookup takes three machine cycles after it is accepted.

A sticky bank bit adds a seventh, top page bit, so the page field can reach either the low or the high half of a 128-page ROM. Two dedicated instructions set and clear the bank bit. Reset clears it, and so does the wake-up event that follows a RAM back-up period. The same return stack also serves the core's subroutine call and return, so those two operations are decoded here as well.

Top module: `tl_lookup_seq`

## Requirements
- R1: After reset, pc_o is 0, and bank_o, ovf_o, busy_o, done_o and rom_re_o are all 0. The stack holds no entries.
- R2: An accepted word whose top four bits are 0010 starts a lookup when a stack level is free. busy_o is then high for exactly the three cycles after the accepting edge, and done_o is high only in the third of those cycles.
- R3: In the first busy cycle, rom_re_o is high for one cycle and rom_addr_o equals {bank, page[5:0], D[2:0], A[3:0]}. The ROM returns its data one cycle later.
- R4: The ROM word is written as w_o = bits 9:8, b_o = bits 7:4 and a_o = bits 3:0. All three are valid from the done cycle onward.
- R5: After a lookup, pc_o equals the lookup's own pc_o plus one. The stack level it borrowed is released, and the existing entries are left intact.
- R6: Instruction 10'h3FD sets the bank bit and 10'h3FC clears it. The bit holds its value between these instructions.
- R7: A high wake_i clears the bank bit on the next edge. It wins over a bank-set instruction accepted on the same edge.
- R8: A lookup or a call accepted while the stack holds 8 entries sets the sticky ovf_o flag. It does not go busy, it only advances pc_o, and it leaves the stored entries unchanged.
- R9: Call (10'h3FE) pushes pc_o+1 and loads pc_o from call_tgt_i. Return (10'h3FF) loads pc_o from the top entry and pops it. A return on an empty stack only advances pc_o.
- R10: instr_valid_i is ignored while busy_o is high.
- R11: Any other accepted word advances pc_o by one.
- R12: D and A are sampled on the accepting edge. Changes to reg_d_i and reg_a_i while busy do not affect the ROM address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| wake_i | input | 1 | wake-up from RAM back-up; clears the bank bit |
| instr_valid_i | input | 1 | instruction word present |
| instr_i | input | 10 | instruction word |
| call_tgt_i | input | 14 | target address for a call |
| reg_a_i | input | 4 | current value of register A |
| reg_d_i | input | 3 | current value of register D |
| rom_addr_o | output | 14 | ROM address (the program counter) |
| rom_re_o | output | 1 | table read strobe |
| rom_data_i | input | 10 | ROM word, valid one cycle after the address |
| pc_o | output | 14 | program counter |
| busy_o | output | 1 | lookup in progress |
| done_o | output | 1 | final lookup cycle |
| w_o | output | 2 | ROM word bits 9:8 |
| b_o | output | 4 | ROM word bits 7:4 |
| a_o | output | 4 | ROM word bits 3:0 |
| bank_o | output | 1 | bank bit (high page half) |
| ovf_o | output | 1 | sticky stack overflow flag |

## Verification
The bank bit has two writers that can act on the same edge: the bank-set instruction and the wake-up event. The bench accepts a bank-set word while wake_i is held high in the same cycle, and then requires bank_o to read 0. It also raises wake_i in the middle of a high-bank lookup. The bench then judges two things: the ROM address already issued must still carry the high bank, and bank_o must read 0 afterwards.

// File: rtl/tl_pkg.sv
package tl_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_CAPT, ST_REST} tl_state_e;
  typedef enum logic [2:0] {OP_NOP, OP_LOOKUP, OP_BSET, OP_BCLR, OP_CALL, OP_RET} tl_op_e;
  localparam logic [3:0] LOOKUP_PFX = 4'b0010;
endpackage

// File: rtl/tl_decode.sv
module tl_decode
  import tl_pkg::*;
#(
  parameter int IW = 10
) (
  input  logic [IW-1:0] instr_i,
  output tl_op_e        op_o
);
  localparam logic [IW-1:0] CODE_BCLR = {{(IW-2){1'b1}}, 2'b00};
  localparam logic [IW-1:0] CODE_BSET = {{(IW-2){1'b1}}, 2'b01};
  localparam logic [IW-1:0] CODE_CALL = {{(IW-2){1'b1}}, 2'b10};
  localparam logic [IW-1:0] CODE_RET  = {{(IW-2){1'b1}}, 2'b11};

  always_comb begin
    op_o = OP_NOP;
    if (instr_i[IW-1 -: 4] == LOOKUP_PFX) op_o = OP_LOOKUP;
    else if (instr_i == CODE_BSET)        op_o = OP_BSET;
    else if (instr_i == CODE_BCLR)        op_o = OP_BCLR;
    else if (instr_i == CODE_CALL)        op_o = OP_CALL;
    else if (instr_i == CODE_RET)         op_o = OP_RET;
  end
endmodule

// File: rtl/tl_stack.sv
module tl_stack #(
  parameter int DEPTH = 8,
  parameter int W     = 14,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [W-1:0]  data_i,
  output logic [W-1:0]  top_o,
  output logic          full_o,
  output logic          empty_o,
  output logic [CW-1:0] level_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [CW-1:0] level_q;
  logic          do_push, do_pop;

  assign full_o  = (level_q == CW'(DEPTH));
  assign empty_o = (level_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 mem_q[g] <= '0;
      else if (do_push && level_q == CW'(g))       mem_q[g] <= data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 level_q <= '0;
    else if (do_push && !do_pop) level_q <= level_q + CW'(1);
    else if (do_pop && !do_push) level_q <= level_q - CW'(1);
  end

  logic [CW-1:0] top_idx;
  assign top_idx = level_q - CW'(1);
  assign top_o   = mem_q[AW'(top_idx)];
  assign level_o = level_q;
endmodule

// File: rtl/tl_lookup_seq.sv
module tl_lookup_seq
  import tl_pkg::*;
#(
  parameter int PAGE_W  = 6,
  parameter int D_W     = 3,
  parameter int NIB     = 4,
  parameter int W_W     = 2,
  parameter int DEPTH   = 8,
  localparam int IW     = 4 + PAGE_W,
  localparam int PC_W   = 1 + PAGE_W + D_W + NIB,
  localparam int DATA_W = W_W + 2 * NIB,
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wake_i,
  input  logic              instr_valid_i,
  input  logic [IW-1:0]     instr_i,
  input  logic [PC_W-1:0]   call_tgt_i,
  input  logic [NIB-1:0]    reg_a_i,
  input  logic [D_W-1:0]    reg_d_i,
  output logic [PC_W-1:0]   rom_addr_o,
  output logic              rom_re_o,
  input  logic [DATA_W-1:0] rom_data_i,
  output logic [PC_W-1:0]   pc_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [W_W-1:0]    w_o,
  output logic [NIB-1:0]    b_o,
  output logic [NIB-1:0]    a_o,
  output logic              bank_o,
  output logic              ovf_o
);
  tl_state_e         state_q;
  tl_op_e            op;
  logic [PC_W-1:0]   pc_q, pc_inc, stk_top;
  logic              bank_q, ovf_q;
  logic [W_W-1:0]    w_q;
  logic [NIB-1:0]    b_q, a_q;
  logic              acc, stk_push, stk_pop, stk_full, stk_empty;
  logic [CW-1:0]     stk_level;
  logic              is_lookup, is_call, needs_level;

  tl_decode #(.IW(IW)) i_dec (.instr_i(instr_i), .op_o(op));

  assign acc         = instr_valid_i && (state_q == ST_IDLE);
  assign is_lookup   = (op == OP_LOOKUP);
  assign is_call     = (op == OP_CALL);
  assign needs_level = is_lookup || is_call;
  assign pc_inc      = pc_q + PC_W'(1);
  assign stk_push    = acc && needs_level && !stk_full;
  assign stk_pop     = (acc && op == OP_RET && !stk_empty) || (state_q == ST_REST);

  tl_stack #(.DEPTH(DEPTH), .W(PC_W)) i_stk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (stk_push),
    .pop_i   (stk_pop),
    .data_i  (pc_inc),
    .top_o   (stk_top),
    .full_o  (stk_full),
    .empty_o (stk_empty),
    .level_o (stk_level)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pc_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (acc) begin
          unique case (op)
            OP_LOOKUP: if (stk_full) pc_q <= pc_inc;
                       else begin
                         pc_q    <= {bank_q, instr_i[PAGE_W-1:0], reg_d_i, reg_a_i};
                         state_q <= ST_FETCH;
                       end
            OP_CALL:   pc_q <= stk_full ? pc_inc : call_tgt_i;
            OP_RET:    pc_q <= stk_empty ? pc_inc : stk_top;
            default:   pc_q <= pc_inc;
          endcase
        end
        ST_FETCH: state_q <= ST_CAPT;
        ST_CAPT:  state_q <= ST_REST;
        ST_REST: begin
          pc_q    <= stk_top;
          state_q <= ST_IDLE;
        end
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     bank_q <= 1'b0;
    else if (wake_i)                 bank_q <= 1'b0;
    else if (acc && op == OP_BSET)   bank_q <= 1'b1;
    else if (acc && op == OP_BCLR)   bank_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             ovf_q <= 1'b0;
    else if (acc && needs_level && stk_full) ovf_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w_q <= '0;
      b_q <= '0;
      a_q <= '0;
    end else if (state_q == ST_CAPT) begin
      {w_q, b_q, a_q} <= rom_data_i;
    end
  end

  assign rom_addr_o = pc_q;
  assign rom_re_o   = (state_q == ST_FETCH);
  assign pc_o       = pc_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_REST);
  assign w_o        = w_q;
  assign b_o        = b_q;
  assign a_o        = a_q;
  assign bank_o     = bank_q;
  assign ovf_o      = ovf_q;
endmodule

// File: rtl/tl_lookup_seq_chk.sv
module tl_lookup_seq_chk #(
  parameter int PC_W  = 14,
  parameter int CW    = 4,
  parameter int DEPTH = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            wake_i,
  input logic            busy_o,
  input logic            done_o,
  input logic            rom_re_o,
  input logic [PC_W-1:0] pc_o,
  input logic            bank_o,
  input logic            ovf_o,
  input logic [CW-1:0]   level
);
  AST_BUSY_SPAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> ##2 done_o); // R2
  AST_DONE_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o); // R2
  AST_ROM_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> rom_re_o); // R3
  AST_ROM_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_re_o |=> !rom_re_o && busy_o); // R3
  AST_PC_RESTORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> pc_o == PC_W'($past(pc_o, 4) + PC_W'(1))); // R5
  AST_LEVEL_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> $stable(level)); // R5
  AST_LEVEL_FREED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> level == CW'($past(level) - CW'(1))); // R5
  AST_WAKE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_i |=> !bank_o); // R7
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o); // R8
  AST_LEVEL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level <= CW'(DEPTH)); // R8
endmodule

bind tl_lookup_seq tl_lookup_seq_chk #(.PC_W(PC_W), .CW(CW), .DEPTH(DEPTH)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wake_i   (wake_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .rom_re_o (rom_re_o),
  .pc_o     (pc_o),
  .bank_o   (bank_o),
  .ovf_o    (ovf_o),
  .level    (stk_level)
);

// File: tb/test_tl_lookup_seq.sv
`timescale 1ns/1ps
module test_tl_lookup_seq;
  localparam logic [9:0] C_BCLR = 10'h3FC, C_BSET = 10'h3FD, C_CALL = 10'h3FE, C_RET = 10'h3FF;

  logic clk = 0, rst_n = 0, wake = 0, iv = 0;
  logic [9:0] instr = '0;
  logic [13:0] tgt = '0;
  logic [3:0] ra = '0;
  logic [2:0] rd = '0;
  logic [13:0] rom_addr, pc;
  logic rom_re, busy, done, bank, ovf;
  logic [9:0] rom_q;
  logic [1:0] w;
  logic [3:0] b, a;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  tl_lookup_seq i_tl_lookup_seq (
    .clk_i(clk), .rst_ni(rst_n), .wake_i(wake), .instr_valid_i(iv), .instr_i(instr),
    .call_tgt_i(tgt), .reg_a_i(ra), .reg_d_i(rd), .rom_addr_o(rom_addr), .rom_re_o(rom_re),
    .rom_data_i(rom_q), .pc_o(pc), .busy_o(busy), .done_o(done), .w_o(w), .b_o(b),
    .a_o(a), .bank_o(bank), .ovf_o(ovf)
  );

  function automatic logic [9:0] rom_fn(input logic [13:0] ad);
    logic [23:0] t;
    t = {10'd0, ad} * 24'd37 + 24'(ad >> 7);
    return t[9:0];
  endfunction

  always_ff @(posedge clk) rom_q <= rom_fn(rom_addr);

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic exec(input logic [9:0] ins);
    @(negedge clk); iv = 1; instr = ins;
    @(negedge clk); iv = 0; instr = '0;
  endtask

  // full lookup with checks; returns at negedge after pc restore
  task automatic lookup(input logic [5:0] pg, input logic [2:0] dd, input logic [3:0] aa, input logic bk);
    logic [13:0] p0, ea;
    logic [9:0] ed;
    ra = aa; rd = dd;
    @(negedge clk); p0 = pc;
    iv = 1; instr = {4'b0010, pg};
    @(negedge clk); iv = 0; instr = '0;
    ea = {bk, pg, dd, aa}; ed = rom_fn(ea);
    chk(busy && rom_re && !done, "R2", "busy/strobe c1", {busy, rom_re, done}, 3'b110);
    chk(rom_addr == ea, "R3", "rom addr", rom_addr, ea);
    ra = ~aa; rd = ~dd; // R12: late changes must not matter
    @(negedge clk);
    chk(busy && !rom_re && !done, "R2", "busy c2", {busy, rom_re, done}, 3'b100);
    chk(rom_addr == ea, "R12", "addr held", rom_addr, ea);
    @(negedge clk);
    chk(busy && done, "R2", "done c3", {busy, done}, 2'b11);
    chk({w, b, a} == ed, "R4", "w/b/a split", {w, b, a}, ed);
    @(negedge clk);
    chk(!busy && !done, "R2", "idle after", {busy, done}, 2'b00);
    chk(pc == p0 + 14'd1, "R5", "pc restored", pc, p0 + 14'd1);
    chk(w == ed[9:8] && b == ed[7:4] && a == ed[3:0], "R4", "fields held", {w, b, a}, ed);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [13:0] ret_exp [8];
    logic [13:0] p0;
    repeat (3) @(negedge clk);
    chk(pc == 0 && !bank && !ovf && !busy && !done && !rom_re, "R1", "reset state",
        {pc, bank, ovf, busy, done, rom_re}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(pc == 0 && !busy, "R1", "after release", pc, 0);

    // R11: plain words and near-miss prefix advance pc
    p0 = pc; exec(10'h155);
    chk(pc == p0 + 1 && !busy, "R11", "nop advance", pc, p0 + 1);
    p0 = pc; exec(10'b0011_000001);
    chk(pc == p0 + 1 && !busy, "R11", "prefix 0011 not lookup", pc, p0 + 1);

    // near-exhaustive sweep, both banks
    for (int bk = 0; bk < 2; bk++) begin
      exec(bk ? C_BSET : C_BCLR);
      chk(bank == bk[0], "R6", "bank op", bank, bk);
      for (int pg = 0; pg < 64; pg++)
        for (int dd = 0; dd < 8; dd++)
          for (int ai = 0; ai < 4; ai++)
            lookup(6'(pg), 3'(dd), 4'(ai * 5), bk[0]);
      chk(bank == bk[0], "R6", "bank sticky", bank, bk);
    end

    // R7: wake beats bank-set on the same edge
    @(negedge clk); iv = 1; instr = C_BSET; wake = 1;
    @(negedge clk); iv = 0; wake = 0;
    chk(!bank, "R7", "wake vs set", bank, 0);
    exec(C_BSET);
    chk(bank, "R6", "set again", bank, 1);
    @(negedge clk); wake = 1; @(negedge clk); wake = 0;
    chk(!bank, "R7", "wake alone", bank, 0);

    // R7: wake mid-lookup with bank high
    exec(C_BSET);
    ra = 4'h9; rd = 3'h2;
    @(negedge clk); p0 = pc; iv = 1; instr = {4'b0010, 6'h2A};
    @(negedge clk); iv = 0; wake = 1;
    chk(rom_addr == {1'b1, 6'h2A, 3'h2, 4'h9}, "R7", "addr keeps bank", rom_addr, {1'b1, 6'h2A, 3'h2, 4'h9});
    @(negedge clk); wake = 0;
    @(negedge clk); @(negedge clk);
    chk(!bank && pc == p0 + 1, "R7", "bank cleared after", {bank, pc}, {1'b0, p0 + 14'd1});

    // R10: words during busy ignored
    @(negedge clk); p0 = pc; iv = 1; instr = {4'b0010, 6'h01};
    @(negedge clk); instr = C_BSET;
    @(negedge clk); instr = C_CALL; tgt = 14'h3000;
    @(negedge clk); iv = 0; instr = '0;
    @(negedge clk);
    chk(!bank && pc == p0 + 1 && !busy, "R10", "busy ignores", {bank, pc}, {1'b0, p0 + 14'd1});

    // R9/R5/R8: fill stack with a lookup nested at depth 7
    for (int k = 0; k < 8; k++) begin
      if (k == 7) lookup(6'h11, 3'h5, 4'hC, 1'b0);
      ret_exp[k] = pc + 14'd1;
      tgt = 14'h0100 + 14'(k * 3);
      exec(C_CALL);
      chk(pc == tgt, "R9", "call jump", pc, tgt);
    end
    p0 = pc; exec({4'b0010, 6'h07});
    chk(!busy && ovf && pc == p0 + 1, "R8", "lookup when full", {busy, ovf, pc}, {2'b01, p0 + 14'd1});
    @(negedge clk);
    chk(!busy && !done, "R8", "no sequence", {busy, done}, 0);
    p0 = pc; tgt = 14'h2222; exec(C_CALL);
    chk(ovf && pc == p0 + 1, "R8", "call when full", pc, p0 + 1);
    for (int k = 7; k >= 0; k--) begin
      exec(C_RET);
      chk(pc == ret_exp[k], "R8", "entries intact", pc, ret_exp[k]);
    end
    p0 = pc; exec(C_RET);
    chk(pc == p0 + 1, "R9", "ret on empty", pc, p0 + 1);
    chk(ovf, "R8", "ovf sticky", ovf, 1);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule